// File: doc/BRIEF.md
# Tag-Indexed Burst Data Buffer

This block keeps request data out of the request queues of a memory controller. A client that wants to post a burst asks for a tag. The buffer grants the lowest-numbered free slot, or holds the grant low while every slot is in use. The request queues then carry only that tag.

For a write, the client fills the slot with one burst of beats. The slot is drained when the bank scheduler issues the request, and the slot frees itself after the last beat leaves. For a read, the slot is reserved at allocation time. The memory's return data fills it, the client drains it, and the slot frees itself after the client takes its last beat. Data is written once into its slot and read once from it; nothing is ever copied between buffers.

Each slot keeps its own fill and drain beat counters, so the interfaces only present a tag. The fill and drain of different slots may interleave freely.

Top module: `tag_data_buffer`

## Requirements
- R1: After reset every slot is free: `free_map` is all ones and an allocation request is granted.
- R2: A granted allocation returns the lowest-numbered free slot as `alloc_tag`. That slot's bit in `free_map` is clear from the next cycle.
- R3: When no slot is free, `alloc_gnt` stays low and a request leaves `free_map` unchanged.
- R4: Beats written with `wfill_vld` for a tag are presented on `iss_data` in the same order, one beat per cycle in which `iss_vld` names that tag. Beat 0 comes first.
- R5: `iss_last` is high exactly on the final beat (beat BEATS-1) of a slot being issued. The slot's `free_map` bit is set in the next cycle.
- R6: Beats written with `ret_vld` for a tag are presented on `cli_data` in the same order when `cli_vld` names that tag.
- R7: `cli_last` is high exactly on the final beat of a slot being drained by the client. The slot's `free_map` bit is set in the next cycle.
- R8: Filling or draining one slot does not change the data or the beat position of any other slot, for any interleaving of slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request for a free slot |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_tag | output | TAG_W | Granted slot number |
| free_map | output | NUM_SLOTS | One bit per slot, 1 = free |
| wfill_vld | input | 1 | Write-data beat valid |
| wfill_tag | input | TAG_W | Slot receiving the write beat |
| wfill_data | input | DATA_W | Write-data beat |
| iss_vld | input | 1 | Issue-time readout of one beat |
| iss_tag | input | TAG_W | Slot being issued |
| iss_data | output | DATA_W | Current beat of the issued slot |
| iss_last | output | 1 | Current issued beat is the last one |
| ret_vld | input | 1 | Memory read-return beat valid |
| ret_tag | input | TAG_W | Slot receiving the returned beat |
| ret_data | input | DATA_W | Returned beat |
| cli_vld | input | 1 | Client takes one read beat |
| cli_tag | input | TAG_W | Slot being drained by the client |
| cli_data | output | DATA_W | Current beat of the drained slot |
| cli_last | output | 1 | Current client beat is the last one |

## Verification
A wrong free bitmap shows at the allocation port in the same cycle. The buffer either grants a tag that is still in use, grants a tag other than the lowest free one, or refuses while a slot is idle. A fault in a beat counter shows on the first readout of the affected slot: its data comes out of order, or the last flag comes on the wrong beat. The bitmap then misses the release one cycle after the expected final beat. Random interleavings across slots catch counters or writes that land on the wrong slot, because the damaged slot fails its next readout.

// File: rtl/tag_data_buffer_pkg.sv
// Package: shared default sizes for the tag-indexed data buffer.
// Assumes: beats per burst is a power of two and at least two.
package tag_data_buffer_pkg;
    localparam int DEF_SLOTS  = 4;
    localparam int DEF_BEATS  = 4;
    localparam int DEF_DATA_W = 16;
endpackage

// File: rtl/tdb_slot_alloc.sv
// Module: free-slot bitmap with a lowest-index picker.
// Assumes: a released slot is never the slot being granted in the same cycle.
module tdb_slot_alloc #(
    parameter int NUM_SLOTS = 4,
    localparam int TAG_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [NUM_SLOTS-1:0] release_vec,
    output logic                 gnt,
    output logic [TAG_W-1:0]     tag,
    output logic [NUM_SLOTS-1:0] free_q
);
    logic [NUM_SLOTS-1:0] take_vec;

    // Pick the lowest set bit of the free bitmap.
    always_comb begin
        tag = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_q[i]) tag = TAG_W'(i);
        end
    end

    assign gnt      = req && (|free_q);
    assign take_vec = gnt ? (NUM_SLOTS'(1) << tag) : '0;

    // Update the bitmap: clear the granted slot, set the released slots.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= (free_q & ~take_vec) | release_vec;
    end
endmodule

// File: rtl/tdb_slot_store.sv
// Module: per-slot burst storage with fill and drain beat counters.
// Assumes: a slot is filled from one source only, and drained from one sink
// only, and only after it is full. Wrapping counters return to beat 0.
module tdb_slot_store #(
    parameter int NUM_SLOTS = 4,
    parameter int BEATS     = 4,
    parameter int DATA_W    = 16,
    localparam int TAG_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wf_vld,
    input  logic [TAG_W-1:0]     wf_tag,
    input  logic [DATA_W-1:0]    wf_data,
    input  logic                 rt_vld,
    input  logic [TAG_W-1:0]     rt_tag,
    input  logic [DATA_W-1:0]    rt_data,
    input  logic                 is_vld,
    input  logic [TAG_W-1:0]     is_tag,
    output logic [DATA_W-1:0]    is_data,
    output logic                 is_last,
    input  logic                 cl_vld,
    input  logic [TAG_W-1:0]     cl_tag,
    output logic [DATA_W-1:0]    cl_data,
    output logic                 cl_last,
    output logic [NUM_SLOTS-1:0] release_vec
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    logic [DATA_W-1:0] mem_q   [NUM_SLOTS][BEATS];
    logic [BEAT_W-1:0] fill_q  [NUM_SLOTS];
    logic [BEAT_W-1:0] drain_q [NUM_SLOTS];

    // Store the incoming beats at each slot's fill position.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (wf_vld && wf_tag == TAG_W'(s))
                mem_q[s][fill_q[s]] <= wf_data;
            else if (rt_vld && rt_tag == TAG_W'(s))
                mem_q[s][fill_q[s]] <= rt_data;
        end
    end

    // Advance the fill and drain counters of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                fill_q[s]  <= '0;
                drain_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if ((wf_vld && wf_tag == TAG_W'(s)) || (rt_vld && rt_tag == TAG_W'(s)))
                    fill_q[s] <= (fill_q[s] == LAST_BEAT) ? '0 : fill_q[s] + 1'b1;
                if ((is_vld && is_tag == TAG_W'(s)) || (cl_vld && cl_tag == TAG_W'(s)))
                    drain_q[s] <= (drain_q[s] == LAST_BEAT) ? '0 : drain_q[s] + 1'b1;
            end
        end
    end

    // Present the current beat of each readout port.
    always_comb begin
        is_data = mem_q[is_tag][drain_q[is_tag]];
        is_last = (drain_q[is_tag] == LAST_BEAT);
        cl_data = mem_q[cl_tag][drain_q[cl_tag]];
        cl_last = (drain_q[cl_tag] == LAST_BEAT);
    end

    // Flag a slot for release when its final beat leaves.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rel
        assign release_vec[g] = (drain_q[g] == LAST_BEAT) &&
                                ((is_vld && is_tag == TAG_W'(g)) ||
                                 (cl_vld && cl_tag == TAG_W'(g)));
    end
endmodule

// File: rtl/tag_data_buffer.sv
// Module: top of the tag-indexed burst data buffer. It joins the slot
// allocator and the slot storage.
// Assumes: the callers use only tags that were granted, and fill a slot
// completely before they drain it.
module tag_data_buffer
    import tag_data_buffer_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int BEATS     = DEF_BEATS,
    parameter int DATA_W    = DEF_DATA_W,
    localparam int TAG_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    output logic                 alloc_gnt,
    output logic [TAG_W-1:0]     alloc_tag,
    output logic [NUM_SLOTS-1:0] free_map,
    input  logic                 wfill_vld,
    input  logic [TAG_W-1:0]     wfill_tag,
    input  logic [DATA_W-1:0]    wfill_data,
    input  logic                 iss_vld,
    input  logic [TAG_W-1:0]     iss_tag,
    output logic [DATA_W-1:0]    iss_data,
    output logic                 iss_last,
    input  logic                 ret_vld,
    input  logic [TAG_W-1:0]     ret_tag,
    input  logic [DATA_W-1:0]    ret_data,
    input  logic                 cli_vld,
    input  logic [TAG_W-1:0]     cli_tag,
    output logic [DATA_W-1:0]    cli_data,
    output logic                 cli_last
);
    logic [NUM_SLOTS-1:0] release_vec;

    tdb_slot_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (alloc_req),
        .release_vec (release_vec),
        .gnt         (alloc_gnt),
        .tag         (alloc_tag),
        .free_q      (free_map)
    );

    tdb_slot_store #(.NUM_SLOTS(NUM_SLOTS), .BEATS(BEATS), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wf_vld      (wfill_vld),
        .wf_tag      (wfill_tag),
        .wf_data     (wfill_data),
        .rt_vld      (ret_vld),
        .rt_tag      (ret_tag),
        .rt_data     (ret_data),
        .is_vld      (iss_vld),
        .is_tag      (iss_tag),
        .is_data     (iss_data),
        .is_last     (iss_last),
        .cl_vld      (cli_vld),
        .cl_tag      (cli_tag),
        .cl_data     (cli_data),
        .cl_last     (cli_last),
        .release_vec (release_vec)
    );
endmodule

// File: rtl/tag_data_buffer_chk.sv
// Module: property checker bound to the buffer top.
// Assumes: it observes only the ports of the top module.
module tag_data_buffer_chk #(
    parameter int NUM_SLOTS = 4,
    localparam int TAG_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_gnt,
    input logic [TAG_W-1:0]     alloc_tag,
    input logic [NUM_SLOTS-1:0] free_map,
    input logic                 iss_vld,
    input logic [TAG_W-1:0]     iss_tag,
    input logic                 iss_last,
    input logic                 cli_vld,
    input logic [TAG_W-1:0]     cli_tag,
    input logic                 cli_last
);
    // A grant names a slot that is free right now.
    p_gnt_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> free_map[alloc_tag]);

    // A granted slot is in use in the next cycle.
    p_gnt_claims_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> !free_map[$past(alloc_tag)]);

    // No grant while every slot is busy.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_map == '0) |-> !alloc_gnt);

    // The final issued beat frees its slot.
    p_iss_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_last) |=> free_map[$past(iss_tag)]);

    // The final client beat frees its slot.
    p_cli_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cli_vld && cli_last) |=> free_map[$past(cli_tag)]);
endmodule

bind tag_data_buffer tag_data_buffer_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_gnt (alloc_gnt),
    .alloc_tag (alloc_tag),
    .free_map  (free_map),
    .iss_vld   (iss_vld),
    .iss_tag   (iss_tag),
    .iss_last  (iss_last),
    .cli_vld   (cli_vld),
    .cli_tag   (cli_tag),
    .cli_last  (cli_last)
);

// File: tb/sim_tag_data_buffer.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a behavioural model of the slot state that the bench keeps itself.
module sim_tag_data_buffer;
    localparam int NS = 4;
    localparam int NB = 4;
    localparam int DW = 16;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic          alloc_gnt;
    logic [TW-1:0] alloc_tag;
    logic [NS-1:0] free_map;
    logic          wfill_vld = 1'b0;
    logic [TW-1:0] wfill_tag = '0;
    logic [DW-1:0] wfill_data = '0;
    logic          iss_vld = 1'b0;
    logic [TW-1:0] iss_tag = '0;
    logic [DW-1:0] iss_data;
    logic          iss_last;
    logic          ret_vld = 1'b0;
    logic [TW-1:0] ret_tag = '0;
    logic [DW-1:0] ret_data = '0;
    logic          cli_vld = 1'b0;
    logic [TW-1:0] cli_tag = '0;
    logic [DW-1:0] cli_data;
    logic          cli_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Model of the slot state.
    bit            m_free [NS];
    bit            m_rd   [NS];
    int            m_fill [NS];
    int            m_drn  [NS];
    logic [DW-1:0] m_mem  [NS][NB];

    always #5 clk = ~clk;

    tag_data_buffer #(.NUM_SLOTS(NS), .BEATS(NB), .DATA_W(DW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] model_map();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = m_free[i];
        return v;
    endfunction

    function automatic int model_lowest();
        for (int i = 0; i < NS; i++) if (m_free[i]) return i;
        return -1;
    endfunction

    task automatic idle();
        alloc_req = 0; wfill_vld = 0; ret_vld = 0; iss_vld = 0; cli_vld = 0;
    endtask

    // One allocation attempt, checked against the lowest free slot (R2, R3).
    task automatic do_alloc(input bit rd);
        int lo;
        @(negedge clk);
        idle();
        lo = model_lowest();
        alloc_req = 1;
        #1;
        if (lo < 0) begin
            check("R3 gnt when full", 32'(alloc_gnt), 32'd0);
        end else begin
            check("R2 gnt", 32'(alloc_gnt), 32'd1);
            check("R2 lowest tag", 32'(alloc_tag), 32'(lo));
            m_free[lo] = 0; m_rd[lo] = rd; m_fill[lo] = 0; m_drn[lo] = 0;
        end
        @(posedge clk);
        @(negedge clk);
        idle();
        check("R2 R3 free_map", 32'(free_map), 32'(model_map()));
    endtask

    // One beat into slot s through the port that matches its kind (R4, R6).
    task automatic do_fill(input int s);
        logic [DW-1:0] d;
        @(negedge clk);
        idle();
        d = DW'($urandom);
        if (m_rd[s]) begin ret_vld = 1; ret_tag = TW'(s); ret_data = d; end
        else begin wfill_vld = 1; wfill_tag = TW'(s); wfill_data = d; end
        m_mem[s][m_fill[s]] = d;
        m_fill[s]++;
        @(posedge clk);
    endtask

    // One beat out of slot s, with data and last flag checked (R4-R8).
    task automatic do_drain(input int s);
        bit lst;
        @(negedge clk);
        idle();
        lst = (m_drn[s] == NB - 1);
        if (m_rd[s]) begin
            cli_vld = 1; cli_tag = TW'(s);
            #1;
            check("R6 R8 cli_data", 32'(cli_data), 32'(m_mem[s][m_drn[s]]));
            check("R7 cli_last", 32'(cli_last), 32'(lst));
        end else begin
            iss_vld = 1; iss_tag = TW'(s);
            #1;
            check("R4 R8 iss_data", 32'(iss_data), 32'(m_mem[s][m_drn[s]]));
            check("R5 iss_last", 32'(iss_last), 32'(lst));
        end
        m_drn[s]++;
        if (m_drn[s] == NB) m_free[s] = 1;
        @(posedge clk);
        @(negedge clk);
        idle();
        if (lst) check(m_rd[s] ? "R7 release" : "R5 release",
                       32'(free_map), 32'(model_map()));
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_free[i] = 1; m_rd[i] = 0; m_fill[i] = 0; m_drn[i] = 0;
        end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        alloc_req = 1;
        #1;
        check("R1 free_map", 32'(free_map), 32'hF);
        check("R1 gnt", 32'(alloc_gnt), 32'd1);
        alloc_req = 0;

        // Directed: fill every slot, then ask once more while full (R2, R3).
        for (int i = 0; i < NS; i++) do_alloc(i[0]);
        do_alloc(0);
        // Interleave beats of slots 2 and 1, then free slot 2 first (R8, R2).
        for (int b = 0; b < NB; b++) begin do_fill(2); do_fill(1); end
        for (int b = 0; b < NB; b++) do_drain(2);
        do_alloc(1);
        for (int b = 0; b < NB; b++) do_drain(1);

        // Random operations driven from the model state.
        for (int it = 0; it < 3000; it++) begin
            int op, s0, s;
            op = int'($urandom % 3);
            s0 = int'($urandom % NS);
            s = -1;
            if (op == 0) begin
                do_alloc(bit'($urandom % 2));
            end else begin
                for (int k = 0; k < NS; k++) begin
                    int c;
                    c = (s0 + k) % NS;
                    if (s < 0 && !m_free[c]) begin
                        if (op == 1 && m_fill[c] < NB) s = c;
                        if (op == 2 && m_fill[c] == NB) s = c;
                    end
                end
                if (s >= 0) begin
                    if (op == 1) do_fill(s);
                    else do_drain(s);
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule